// File: doc/BRIEF.md
# Timer/Counter with Shared Prescaler

This block is an 8-bit timer/counter for a microcontroller core. It advances either once per instruction cycle or on a chosen edge of an external input pin. The instruction-cycle enable `cyc_en_i` marks the instruction-cycle boundaries inside the faster `clk_i` domain. An overflow from all-ones to zero raises a sticky interrupt flag, and software can load the count register through a bus write port at any time.

A single 8-bit scaling counter is shared. When it is given to the timer, it divides the timer events by a power of two chosen by a 3-bit ratio field. When it is given to the watchdog, it divides the raw watchdog events `wdt_evt_i`, and the timer then counts every event at 1:1. The pin passes through a two-stage synchronizer clocked on instruction cycles and then through an edge detector. A software write clears the scaling counter and holds off counting for the next two instruction cycles.

Top module: `tick_timer`

## Requirements
- R1: After reset, `count_o` is 0x00, `flag_o` is 0, and the scaling counter is cleared.
- R2: With `src_ext_i`=0 and `psc_to_wdt_i`=1, `count_o` rises by one at every clock edge where `cyc_en_i`=1, unless counting is held off.
- R3: With `psc_to_wdt_i`=0, the scaling counter advances on every qualified timer event. `count_o` rises by one on the event where the low (sel+1) bits of the scaling counter are all ones, which gives a ratio of 1:2^(sel+1) for `psc_sel_i`=sel (0..7).
- R4: With `src_ext_i`=1, the pin is sampled at instruction-cycle edges. When `edge_fall_i`=0 only a 0-to-1 change counts, and when it is 1 only a 1-to-0 change counts. `count_o` changes at the second instruction-cycle edge after the edge that first samples the new pin level.
- R5: An increment from 0xFF to 0x00 sets `flag_o` at the same clock edge.
- R6: `flag_o` stays set until a clock edge with `flag_clr_i`=1. An overflow at that same edge leaves the flag set.
- R7: A clock edge with `wr_en_i`=1 loads `wr_data_i` into `count_o` and clears the scaling counter. The write wins over a same-edge increment, and an overflow at that edge does not set the flag.
- R8: Timer events at the first two `cyc_en_i` edges after a write are dropped, and they advance neither the count nor the scaling counter.
- R9: With `psc_to_wdt_i`=1, `wdt_tick_o` is high during a cycle with `wdt_evt_i`=1 only when the low `sel` bits of the scaling counter are all ones (1:2^sel), and the counter then advances at that edge. With `psc_to_wdt_i`=0, `wdt_tick_o` equals `wdt_evt_i`.
- R10: `count_o` does not change at a clock edge with `cyc_en_i`=0 and `wr_en_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_en_i | input | 1 | Instruction-cycle enable |
| ext_clk_i | input | 1 | External count pin, asynchronous |
| src_ext_i | input | 1 | Clock source: 0 selects instruction cycles, 1 selects the pin |
| edge_fall_i | input | 1 | Pin edge: 0 selects rising, 1 selects falling |
| psc_to_wdt_i | input | 1 | Scaling counter owner: 0 selects the timer, 1 selects the watchdog |
| psc_sel_i | input | 3 | Ratio select |
| wdt_evt_i | input | 1 | Raw watchdog event |
| wr_en_i | input | 1 | Count register write strobe |
| wr_data_i | input | 8 | Count register write data |
| flag_clr_i | input | 1 | Interrupt flag clear |
| count_o | output | 8 | Count register |
| flag_o | output | 1 | Overflow interrupt flag |
| wdt_tick_o | output | 1 | Scaled watchdog tick |

## Verification
The bench builds the block with its default parameters: an 8-bit count, an 8-bit scaling counter, a 3-bit ratio field, two synchronizer stages and a two-cycle hold after writes. With these values every ratio up to 1:256 fits inside the scaling counter. Written values near 0xFF make overflows, and the flag-clear collisions they bring, happen often in a short run. The full pin pipeline latency can also be checked cycle by cycle against a bench-side model.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic {
    CLK_SRC_CYCLE = 1'b0,
    CLK_SRC_PIN   = 1'b1
  } clk_src_e;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/tick_timer_edge.sv
module tick_timer_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic pin_i,
  input  logic fall_i,
  output logic evt_o
);
  import tick_timer_pkg::*;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              level;
  logic              rise_det;
  logic              fall_det;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    sync_q[0] <= 1'b0;
        else if (adv_i) sync_q[0] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    sync_q[g] <= 1'b0;
        else if (adv_i) sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign level = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prev_q <= 1'b0;
    else if (adv_i) prev_q <= level;
  end

  assign rise_det = level & ~prev_q;
  assign fall_det = ~level & prev_q;
  assign evt_o    = adv_i & ((edge_sel_e'(fall_i) == EDGE_FALL) ? fall_det : rise_det);
endmodule

// File: rtl/tick_timer_psc.sv
module tick_timer_psc #(
  parameter int unsigned PSC_W = 8,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             to_wdt_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             tmr_evt_i,
  input  logic             wdt_evt_i,
  output logic             tmr_tick_o,
  output logic             wdt_tick_o
);
  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] tmr_mask;
  logic [PSC_W-1:0] wdt_mask;
  logic             tmr_full;
  logic             wdt_full;
  logic             step;

  // timer ratio is one power above the watchdog ratio for the same select
  always_comb begin
    for (int i = 0; i < int'(PSC_W); i++) begin
      tmr_mask[i] = (i <= int'(sel_i));
      wdt_mask[i] = (i <  int'(sel_i));
    end
  end

  assign tmr_full = ((psc_q & tmr_mask) == tmr_mask);
  assign wdt_full = ((psc_q & wdt_mask) == wdt_mask);

  assign tmr_tick_o = to_wdt_i ? tmr_evt_i : (tmr_evt_i & tmr_full);
  assign wdt_tick_o = to_wdt_i ? (wdt_evt_i & wdt_full) : wdt_evt_i;
  assign step       = to_wdt_i ? wdt_evt_i : tmr_evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     psc_q <= '0;
    else if (clr_i)  psc_q <= '0;
    else if (step)   psc_q <= psc_q + 1'b1;
  end
endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             evt_i,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             clr_i,
  output logic             qual_o,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o
);
  localparam int unsigned HOLD_W = $clog2(HOLD_CYC + 1);

  logic [HOLD_W-1:0] hold_q;
  logic [CNT_W-1:0]  count_q;
  logic              flag_q;
  logic              wrap;

  assign qual_o = evt_i & (hold_q == '0);
  assign wrap   = tick_i & ~wr_en_i & (count_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    hold_q <= '0;
    else if (wr_en_i)               hold_q <= HOLD_W'(HOLD_CYC);
    else if (adv_i && hold_q != '0) hold_q <= hold_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_q <= '0;
    else if (wr_en_i) count_q <= wr_data_i;
    else if (tick_i)  count_q <= count_q + 1'b1;
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (wrap)  flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign count_o = count_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned PSC_W       = 8,
  parameter int unsigned SEL_W       = tick_timer_pkg::SEL_W,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYC    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_en_i,
  input  logic             ext_clk_i,
  input  logic             src_ext_i,
  input  logic             edge_fall_i,
  input  logic             psc_to_wdt_i,
  input  logic [SEL_W-1:0] psc_sel_i,
  input  logic             wdt_evt_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o,
  output logic             wdt_tick_o
);
  import tick_timer_pkg::*;

  logic pin_evt;
  logic raw_evt;
  logic qual_evt;
  logic tmr_tick;

  tick_timer_edge #(
    .STAGES (SYNC_STAGES)
  ) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (cyc_en_i),
    .pin_i  (ext_clk_i),
    .fall_i (edge_fall_i),
    .evt_o  (pin_evt)
  );

  assign raw_evt = (clk_src_e'(src_ext_i) == CLK_SRC_PIN) ? pin_evt : cyc_en_i;

  tick_timer_psc #(
    .PSC_W (PSC_W),
    .SEL_W (SEL_W)
  ) u_psc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (wr_en_i),
    .to_wdt_i   (psc_to_wdt_i),
    .sel_i      (psc_sel_i),
    .tmr_evt_i  (qual_evt),
    .wdt_evt_i  (wdt_evt_i),
    .tmr_tick_o (tmr_tick),
    .wdt_tick_o (wdt_tick_o)
  );

  tick_timer_core #(
    .CNT_W    (CNT_W),
    .HOLD_CYC (HOLD_CYC)
  ) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (cyc_en_i),
    .evt_i     (raw_evt),
    .tick_i    (tmr_tick),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .clr_i     (flag_clr_i),
    .qual_o    (qual_evt),
    .count_o   (count_o),
    .flag_o    (flag_o)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SEL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cyc_en_i,
  input logic             ext_clk_i,
  input logic             src_ext_i,
  input logic             edge_fall_i,
  input logic             psc_to_wdt_i,
  input logic [SEL_W-1:0] psc_sel_i,
  input logic             wdt_evt_i,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic             flag_clr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             flag_o,
  input logic             wdt_tick_o
);
  a_r7_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> count_o == $past(wr_data_i));

  a_r5_wrap_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '1 && !wr_en_i) |=> (count_o != '0 || flag_o));

  a_r6_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);

  a_r8_hold_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i) && !wr_en_i) |=> $stable(count_o));

  a_r10_idle_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cyc_en_i && !wr_en_i) |=> $stable(count_o));

  a_r2_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (count_o == $past(count_o) || count_o == CNT_W'($past(count_o) + 1'b1)));

  a_r9_wdt_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psc_to_wdt_i |-> wdt_tick_o == wdt_evt_i);

  a_r9_wdt_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdt_evt_i |-> !wdt_tick_o);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/tick_timer_test.sv
module tick_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int SEL_W = 3;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cyc_en_i = 1'b0;
  logic             ext_clk_i = 1'b0;
  logic             src_ext_i = 1'b0;
  logic             edge_fall_i = 1'b0;
  logic             psc_to_wdt_i = 1'b0;
  logic [SEL_W-1:0] psc_sel_i = '0;
  logic             wdt_evt_i = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [CNT_W-1:0] wr_data_i = '0;
  logic             flag_clr_i = 1'b0;
  logic [CNT_W-1:0] count_o;
  logic             flag_o;
  logic             wdt_tick_o;

  tick_timer uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model
  logic [1:0] m_sync;
  logic       m_prev;
  logic [7:0] m_psc;
  logic [7:0] m_cnt;
  int         m_hold;
  logic       m_flag;

  function automatic logic [7:0] tmr_mask(int s);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = (i <= s);
    return m;
  endfunction

  function automatic logic [7:0] wdt_mask(int s);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = (i < s);
    return m;
  endfunction

  function automatic logic exp_wdt();
    logic [7:0] wm;
    wm = wdt_mask(int'(psc_sel_i));
    return psc_to_wdt_i ? (wdt_evt_i && ((m_psc & wm) == wm)) : wdt_evt_i;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sync = '0; m_prev = 1'b0; m_psc = '0; m_cnt = '0; m_hold = 0; m_flag = 1'b0;
    end else begin
      logic lvl, edg, evt, qual, tick, wrap;
      logic [7:0] tm;
      lvl  = m_sync[1];
      edg  = edge_fall_i ? (!lvl && m_prev) : (lvl && !m_prev);
      evt  = cyc_en_i && (src_ext_i ? edg : 1'b1);
      qual = evt && (m_hold == 0);
      tm   = tmr_mask(int'(psc_sel_i));
      tick = psc_to_wdt_i ? qual : (qual && ((m_psc & tm) == tm));
      wrap = tick && !wr_en_i && (m_cnt == 8'hFF);
      if (cyc_en_i) begin
        m_prev = lvl;
        m_sync = {m_sync[0], ext_clk_i};
      end
      if (wr_en_i) m_psc = '0;
      else if (psc_to_wdt_i ? wdt_evt_i : qual) m_psc = m_psc + 1'b1;
      if (wr_en_i) m_cnt = wr_data_i;
      else if (tick) m_cnt = m_cnt + 1'b1;
      if (wr_en_i) m_hold = 2;
      else if (cyc_en_i && m_hold > 0) m_hold = m_hold - 1;
      if (wrap) m_flag = 1'b1;
      else if (flag_clr_i) m_flag = 1'b0;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check(count_o == m_cnt, src_ext_i ? "R4" : (psc_to_wdt_i ? "R2" : "R3"),
            "model count", int'(count_o), int'(m_cnt));
      check(flag_o == m_flag, "R5", "model flag", int'(flag_o), int'(m_flag));
      check(wdt_tick_o == exp_wdt(), "R9", "model wdt tick", int'(wdt_tick_o), int'(exp_wdt()));
    end
  end

  task automatic tick_n(int n);
    repeat (n) @(negedge clk_i);
    #1;
  endtask

  task automatic write_cnt(logic [7:0] v);
    wr_en_i = 1'b1; wr_data_i = v;
    tick_n(1);
    wr_en_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    int ticks;
    void'($urandom(32'd20240611));
    tick_n(3);
    rst_ni = 1'b1;
    tick_n(1);
    check(count_o == 8'h00, "R1", "reset count", int'(count_o), 0);
    check(flag_o == 1'b0, "R1", "reset flag", int'(flag_o), 0);

    // R2 / R8: internal cycles at 1:1, write hold
    psc_to_wdt_i = 1'b1; cyc_en_i = 1'b1;
    write_cnt(8'h10);
    tick_n(2);
    check(count_o == 8'h10, "R8", "held after write", int'(count_o), 'h10);
    tick_n(3);
    check(count_o == 8'h13, "R2", "count per cycle", int'(count_o), 'h13);

    // R10: no instruction cycles
    cyc_en_i = 1'b0;
    tick_n(5);
    check(count_o == 8'h13, "R10", "idle", int'(count_o), 'h13);

    // R3: prescale 1:2
    cyc_en_i = 1'b1; psc_to_wdt_i = 1'b0; psc_sel_i = 3'd0;
    write_cnt(8'h00);
    tick_n(10);
    check(count_o == 8'h04, "R3", "prescale 1:2", int'(count_o), 4);

    // R5 / R6 / R7: overflow against clear
    psc_to_wdt_i = 1'b1; flag_clr_i = 1'b1;
    write_cnt(8'hFE);
    flag_clr_i = 1'b0;
    tick_n(3);
    check(count_o == 8'hFF, "R7", "loaded then counted", int'(count_o), 'hFF);
    flag_clr_i = 1'b1;
    tick_n(1);
    check(count_o == 8'h00, "R5", "wrap count", int'(count_o), 0);
    check(flag_o == 1'b1, "R6", "set wins over clear", int'(flag_o), 1);
    flag_clr_i = 1'b0;
    tick_n(1);
    check(flag_o == 1'b1, "R6", "flag sticky", int'(flag_o), 1);
    flag_clr_i = 1'b1;
    tick_n(1);
    check(flag_o == 1'b0, "R6", "flag cleared", int'(flag_o), 0);
    flag_clr_i = 1'b0;

    // R7: write on an overflow edge does not set the flag
    write_cnt(8'hFF);
    tick_n(2);
    wr_en_i = 1'b1; wr_data_i = 8'h55;
    tick_n(1);
    wr_en_i = 1'b0;
    check(count_o == 8'h55 && flag_o == 1'b0, "R7", "write beats wrap",
          int'({flag_o, count_o}), 'h55);

    // R4: pin edges and latency
    src_ext_i = 1'b1; edge_fall_i = 1'b0; ext_clk_i = 1'b0;
    tick_n(4);
    write_cnt(8'h20);
    tick_n(4);
    ext_clk_i = 1'b1;
    tick_n(1);
    check(count_o == 8'h20, "R4", "pin latency 1", int'(count_o), 'h20);
    tick_n(1);
    check(count_o == 8'h20, "R4", "pin latency 2", int'(count_o), 'h20);
    tick_n(1);
    check(count_o == 8'h21, "R4", "rising counted", int'(count_o), 'h21);
    ext_clk_i = 1'b0;
    tick_n(4);
    check(count_o == 8'h21, "R4", "falling ignored", int'(count_o), 'h21);
    edge_fall_i = 1'b1;
    ext_clk_i = 1'b1;
    tick_n(4);
    check(count_o == 8'h21, "R4", "rising ignored", int'(count_o), 'h21);
    ext_clk_i = 1'b0;
    tick_n(2);
    check(count_o == 8'h21, "R4", "falling pending", int'(count_o), 'h21);
    tick_n(1);
    check(count_o == 8'h22, "R4", "falling counted", int'(count_o), 'h22);

    // R9: watchdog postscale 1:4
    src_ext_i = 1'b0; cyc_en_i = 1'b0; psc_to_wdt_i = 1'b1; psc_sel_i = 3'd2;
    write_cnt(8'h00);
    ticks = 0;
    for (int k = 0; k < 8; k++) begin
      wdt_evt_i = 1'b1;
      #1;
      if (wdt_tick_o) ticks++;
      tick_n(1);
    end
    wdt_evt_i = 1'b0;
    check(ticks == 2, "R9", "postscale 1:4", ticks, 2);
    psc_to_wdt_i = 1'b0; wdt_evt_i = 1'b1;
    #1;
    check(wdt_tick_o == 1'b1, "R9", "pass-through", int'(wdt_tick_o), 1);
    wdt_evt_i = 1'b0;
    tick_n(1);

    // constrained random against the model
    for (int i = 0; i < 6000; i++) begin
      if (i % 64 == 0) begin
        src_ext_i    = $urandom_range(0, 1);
        edge_fall_i  = $urandom_range(0, 1);
        psc_to_wdt_i = $urandom_range(0, 1);
        psc_sel_i    = SEL_W'($urandom_range(0, 7));
      end
      cyc_en_i   = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 3) == 0) ext_clk_i = ~ext_clk_i;
      wdt_evt_i  = ($urandom_range(0, 2) == 0);
      flag_clr_i = ($urandom_range(0, 15) == 0);
      wr_en_i    = ($urandom_range(0, 31) == 0);
      wr_data_i  = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255))
                                               : 8'($urandom_range(240, 255));
      tick_n(1);
    end
    wr_en_i = 1'b0;
    tick_n(2);
    done = 1'b1;
    finish_run();
  end
endmodule